// File: doc/BRIEF.md
# Per-Core Interprocessor Interrupt Register Block

This block holds the interrupt state for a single processor core in an interprocessor signalling fabric. Other cores raise interrupt bits in a 32-bit pending word. The owning core chooses which of those bits may interrupt it through a 32-bit enable word, and it acknowledges them through a clear port. Eight 32-bit mailbox words sit alongside and carry small messages between cores. The block drives one interrupt line to its core.

Software reaches the block over a simple 32-bit register bus that has a select, a write enable, an address and write data. Read data and an error flag return one cycle after the access. A second path, the post port, lets a remote sender set a single pending bit by its vector number without using the bus. The interrupt line is a sticky flop. A set operation can raise it, and only a clear that leaves no bit pending can lower it. Changing the enable word alone never moves it.

Top module: `ipi_core_regs`

## Requirements
- R1: After synchronous reset the pending word, enable word, all mailbox words, `irq`, `bus_err` and `bus_rdata` are all zero.
- R2: Only address bits [7:0] select a register. Address 0x104 reaches the same register as 0x004.
- R3: The pending word at offset 0x00 is read-only. A write there leaves it unchanged and drives `bus_err` high for exactly the one cycle after the write.
- R4: The enable word at offset 0x04 reads back the value last written to it.
- R5: A write to offset 0x08 ORs the data into the pending word. `irq` goes high on the next edge if the new pending word ANDed with the enable word is nonzero. Otherwise `irq` keeps its value.
- R6: A write to offset 0x0C clears the pending bits that are 1 in the data. `irq` goes low on the next edge only if the pending word is then zero and the enable word is nonzero. This also applies to a clear with data zero.
- R7: `irq` is sticky. Writing the enable word, or a clear that leaves some bit pending, never lowers it.
- R8: Reads of offsets 0x08 and 0x0C return zero.
- R9: Eight mailbox words are read and written at offsets 0x20 to 0x3F. The word index is (offset − 0x20) >> 2.
- R10: A read of an unmapped offset returns zero and leaves `bus_err` low. A write to an unmapped offset changes no register and leaves `bus_err` low.
- R11: A pulse on `post_valid` sets pending bit `post_vec` and follows the same `irq` raise rule as R5. If a clear write arrives in the same cycle, the clear is applied first and the posted bit is then set.
- R12: `bus_rdata` and `bus_err` are valid in the cycle after the access. Read data shows the register as it stood before any update made in the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [7:0] decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after a read, zero otherwise |
| bus_err | output | 1 | One-cycle pulse after a write to the read-only pending word |
| post_valid | input | 1 | Direct set request from a sender |
| post_vec | input | $clog2(DATA_W) | Bit number to set in the pending word |
| irq | output | 1 | Registered interrupt line to the core |

## Verification
The checker assumes that one register access at most is presented per cycle and that `post_vec` always names a bit inside the pending word. The stimulus keeps to this in two ways. Every access is issued by a single driver task that deasserts the select after one clock. Vector numbers are chosen from the 5-bit range only. The post port is driven in the same cycle as a bus access only in the two deliberate overlap cases: a clear together with a post, and a status read together with a post.

// File: rtl/ipi_core_pkg.sv
`timescale 1ns/1ps
package ipi_core_pkg;
  localparam int OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_PEND  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_ENA   = 8'h04;
  localparam logic [OFS_W-1:0] OFS_SET   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_CLR   = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_MBOX  = 8'h20;

  typedef struct packed {
    logic pend;
    logic ena;
    logic set;
    logic clr;
    logic mbox;
  } reg_sel_t;
endpackage

// File: rtl/ipi_decode.sv
`timescale 1ns/1ps
module ipi_decode
  import ipi_core_pkg::*;
#(
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = $clog2(MBOX_WORDS)
) (
  input  logic [OFS_W-1:0] ofs,
  output reg_sel_t         sel,
  output logic [IDX_W-1:0] mb_idx
);
  localparam int SPAN = MBOX_WORDS * 4;

  logic [OFS_W:0] rel;
  logic           unused_rel_lsb;

  assign rel            = {1'b0, ofs} - {1'b0, OFS_MBOX};
  assign unused_rel_lsb = ^rel[1:0];
  assign mb_idx         = rel[IDX_W+1:2];

  always_comb begin
    sel      = '0;
    sel.pend = (ofs == OFS_PEND);
    sel.ena  = (ofs == OFS_ENA);
    sel.set  = (ofs == OFS_SET);
    sel.clr  = (ofs == OFS_CLR);
    sel.mbox = !rel[OFS_W] && (rel < (OFS_W+1)'(SPAN));
  end
endmodule

// File: rtl/ipi_status_ctrl.sv
`timescale 1ns/1ps
module ipi_status_ctrl #(
  parameter int DATA_W = 32,
  localparam int VEC_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena_wr,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              post_valid,
  input  logic [VEC_W-1:0]  post_vec,
  output logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] ena_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] clr_bits;
  logic [DATA_W-1:0] pend_nx;
  logic              raise;
  logic              lower;

  always_comb begin
    set_bits = set_wr ? wdata : '0;
    if (post_valid) set_bits = set_bits | (DATA_W'(1) << post_vec);
    clr_bits = clr_wr ? wdata : '0;
    // clear first, then the set sources
    pend_nx  = (pend_q & ~clr_bits) | set_bits;
    raise    = (set_wr || post_valid) && ((pend_nx & ena_q) != '0);
    lower    = clr_wr && (pend_nx == '0) && (ena_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ena_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      if (ena_wr) ena_q <= wdata;
      if (raise)      irq_q <= 1'b1;
      else if (lower) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
`timescale 1ns/1ps
module ipi_mailbox #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rd_q <= '0;
    end else begin
      if (wr) mem[idx] <= wdata;
      rd_q <= mem[idx];
    end
  end
endmodule

// File: rtl/ipi_core_regs.sv
`timescale 1ns/1ps
module ipi_core_regs
  import ipi_core_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int VEC_W     = $clog2(DATA_W),
  localparam int IDX_W     = $clog2(MBOX_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              post_valid,
  input  logic [VEC_W-1:0]  post_vec,
  output logic              irq
);
  logic [OFS_W-1:0]  ofs;
  reg_sel_t          sel;
  logic [IDX_W-1:0]  mb_idx;
  logic              wr, rd;
  logic [DATA_W-1:0] pend_q, ena_q;
  logic [DATA_W-1:0] mb_rd;
  logic [DATA_W-1:0] reg_rd_q;
  logic              mb_hit_q;
  logic              err_q;
  logic              unused_addr_hi;

  assign ofs            = bus_addr[OFS_W-1:0];
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];
  assign wr             = bus_sel && bus_we;
  assign rd             = bus_sel && !bus_we;

  ipi_decode #(.MBOX_WORDS(MBOX_WORDS)) u_dec (
    .ofs    (ofs),
    .sel    (sel),
    .mb_idx (mb_idx)
  );

  ipi_status_ctrl #(.DATA_W(DATA_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .ena_wr     (wr && sel.ena),
    .set_wr     (wr && sel.set),
    .clr_wr     (wr && sel.clr),
    .wdata      (bus_wdata),
    .post_valid (post_valid),
    .post_vec   (post_vec),
    .pend_q     (pend_q),
    .ena_q      (ena_q),
    .irq_q      (irq)
  );

  ipi_mailbox #(.DATA_W(DATA_W), .WORDS(MBOX_WORDS)) u_mbox (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr && sel.mbox),
    .idx   (mb_idx),
    .wdata (bus_wdata),
    .rd_q  (mb_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      mb_hit_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q    <= wr && sel.pend;
      mb_hit_q <= rd && sel.mbox;
      if (rd && sel.pend)     reg_rd_q <= pend_q;
      else if (rd && sel.ena) reg_rd_q <= ena_q;
      else                    reg_rd_q <= '0;
    end
  end

  assign bus_rdata = mb_hit_q ? mb_rd : reg_rd_q;
  assign bus_err   = err_q;
endmodule

// File: rtl/ipi_core_regs_chk.sv
`timescale 1ns/1ps
module ipi_core_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              post_valid,
  input logic [VEC_W-1:0]  post_vec,
  input logic              irq
);
  logic [7:0] o;
  assign o = bus_addr[7:0];

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && !bus_err && bus_rdata == '0));

  a_r3_err_after_pend_write: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && o == 8'h00) |=> bus_err);

  a_r10_err_only_from_pend: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel && bus_we && o == 8'h00));

  a_r5_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((bus_sel && bus_we && o == 8'h08) || post_valid));

  a_r6_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(bus_sel && bus_we && o == 8'h0C));

  a_r8_set_clr_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && (o == 8'h08 || o == 8'h0C)) |=> bus_rdata == '0);
endmodule

bind ipi_core_regs ipi_core_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .post_valid(post_valid), .post_vec(post_vec), .irq(irq)
);

// File: tb/ipi_core_regs_tb_top.sv
`timescale 1ns/1ps
module ipi_core_regs_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_err;
  logic          post_valid;
  logic [4:0]    post_vec;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int          due;
    logic [31:0] data;
    bit          chk_data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];
  exp_t it;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ipi_core_regs #(.ADDR_W(AW), .DATA_W(DW), .MBOX_WORDS(8)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .post_valid(post_valid), .post_vec(post_vec), .irq(irq)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares scoreboard items in the cycle after their access
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      check(it.due == cyc, {it.tag, " timing"}, 32'(cyc), 32'(it.due));
      check(bus_err === it.err, {it.tag, " err"}, 32'(bus_err), 32'(it.err));
      if (it.chk_data)
        check(bus_rdata === it.data, {it.tag, " data"}, bus_rdata, it.data);
    end
  end

  task automatic push(logic [31:0] d, bit cd, logic e, string tag);
    exp_t x;
    x.due = cyc + 1; x.data = d; x.chk_data = cd; x.err = e; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic e, string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    push('0, 0, e, tag);
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    push(exp, 1, 0, tag);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic post(logic [4:0] v);
    @(negedge clk);
    post_valid = 1; post_vec = v;
    @(posedge clk); #1;
    post_valid = 0;
  endtask

  task automatic clr_and_post(logic [31:0] d, logic [4:0] v, string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 12'h00C; bus_wdata = d;
    post_valid = 1; post_vec = v;
    push('0, 0, 0, tag);
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; post_valid = 0;
  endtask

  task automatic rd_and_post(logic [AW-1:0] a, logic [31:0] exp, logic [4:0] v, string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    post_valid = 1; post_vec = v;
    push(exp, 1, 0, tag);
    @(posedge clk); #1;
    bus_sel = 0; post_valid = 0;
  endtask

  task automatic chk_irq(logic exp, string tag);
    check(irq === exp, tag, 32'(irq), 32'(exp));
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    post_valid = 0; post_vec = '0;
    repeat (4) @(posedge clk); #1;
    rst = 0;
    // R1: reset state
    chk_irq(0, "R1 irq after reset");
    check(bus_err === 0, "R1 err after reset", 32'(bus_err), 0);
    check(bus_rdata === 0, "R1 rdata after reset", bus_rdata, 0);
    rd(12'h000, 0, "R1 pend reset");
    rd(12'h004, 0, "R1 enable reset");
    rd(12'h020, 0, "R1 mbox0 reset");
    rd(12'h03C, 0, "R1 mbox7 reset");

    // R4 / R2
    wr(12'h004, 32'h0000_00F0, 0, "R4 enable write");
    rd(12'h004, 32'h0000_00F0, "R4 enable read");
    rd(12'h104, 32'h0000_00F0, "R2 alias read");

    // R5: set without enabled overlap, then with
    wr(12'h008, 32'h3, 0, "R5 set 3");
    chk_irq(0, "R5 no overlap keeps irq low");
    rd(12'h000, 32'h3, "R5 pend after set");
    wr(12'h008, 32'h10, 0, "R5 set 0x10");
    chk_irq(1, "R5 irq raised");

    // R8
    rd(12'h008, 0, "R8 set reads zero");
    rd(12'h00C, 0, "R8 clr reads zero");

    // R3
    wr(12'h000, 32'hFFFF, 1, "R3 pend write flags err");
    rd(12'h000, 32'h13, "R3 pend unchanged");

    // R7 / R6
    wr(12'h00C, 32'h10, 0, "R7 partial clear");
    chk_irq(1, "R7 partial clear keeps irq");
    wr(12'h004, 32'h0, 0, "R7 enable off");
    chk_irq(1, "R7 enable write keeps irq");
    wr(12'h00C, 32'h3, 0, "R6 clear all with enable zero");
    chk_irq(1, "R6 no drop while enable zero");
    rd(12'h000, 0, "R6 pend empty");
    wr(12'h004, 32'h1, 0, "R4 enable 1");
    wr(12'h00C, 32'h0, 0, "R6 zero clear");
    chk_irq(0, "R6 irq lowered");

    // R11: post port
    post(5'd5);
    chk_irq(0, "R11 post masked");
    rd(12'h000, 32'h20, "R11 pend after post 5");
    post(5'd0);
    chk_irq(1, "R11 post raises irq");
    wr(12'h00C, 32'h21, 0, "R11 clear posts");
    chk_irq(0, "R11 irq lowered");
    wr(12'h008, 32'h4, 0, "R11 set 4");
    clr_and_post(32'h5, 5'd0, "R11 clear with post");
    chk_irq(1, "R11 post after clear raises");
    rd(12'h000, 32'h1, "R11 clear before post");
    wr(12'h00C, 32'h1, 0, "R11 final clear");
    chk_irq(0, "R11 irq low again");

    // R9: mailbox
    for (int i = 0; i < 8; i++)
      wr(12'h020 + AW'(i*4), 32'hA500_0000 | 32'(i*32'h111), 0, "R9 mbox write");
    for (int i = 7; i >= 0; i--)
      rd(12'h020 + AW'(i*4), 32'hA500_0000 | 32'(i*32'h111), "R9 mbox read");
    rd(12'h02E, 32'hA500_0333, "R9 byte offset in word 3");

    // R10: unmapped offsets
    rd(12'h010, 0, "R10 read 0x10");
    rd(12'h040, 0, "R10 read 0x40");
    rd(12'h0FC, 0, "R10 read 0xFC");
    wr(12'h044, 32'hDEAD_BEEF, 0, "R10 write 0x44");
    wr(12'h018, 32'hFFFF_FFFF, 0, "R10 write 0x18");
    rd(12'h03C, 32'hA500_0777, "R10 mbox7 intact");
    rd(12'h000, 0, "R10 pend intact");
    rd(12'h004, 32'h1, "R10 enable intact");

    // R12: read returns pre-update value
    rd_and_post(12'h000, 0, 5'd3, "R12 read shows old pend");
    rd(12'h000, 32'h8, "R12 pend updated");
    chk_irq(0, "R12 masked post");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule